// File: doc/BRIEF.md
# Nibble Handshake Command Port

This block sits on the controller side of a link to a slow peripheral, such as a disc changer. The peripheral accepts commands as a series of 4-bit nibbles. A local requester loads a command of up to sixteen nibbles and pulses `cmd_start`. The block lowers an active-low frame select and sends the nibbles one at a time over a four-phase request/acknowledge handshake. When the last acknowledge has been released, it raises the select again. If either handshake wait runs longer than a limit the requester programs, the block abandons the command and raises an error flag.

The peripheral also sends 4-bit status nibbles on its own initiative. Each nibble is marked by an active-low strobe and is not acknowledged, so it must be taken quickly. The block captures a nibble on the synchronised falling edge of the strobe, which is far inside the device's 230 µs acceptance window. It then gives a one-cycle valid pulse. If a nibble arrives before the previous one has been read, the block records an overrun. Three level signals from the device are passed out after synchronisation: fault/test mode, magazine closed, and powered.

Top module: `nib_cmd_port`

## Requirements
- R1: While reset is held and after it is released, `chg_sel_n` and `chg_req_n` are 1, and `cmd_busy`, `cmd_err`, `stat_valid` and `stat_ovr` are 0. Reset is asserted asynchronously and released on the second rising clock edge after `rst_n` rises.
- R2: A `cmd_start` that is sampled while idle latches `cmd_words` and `cmd_last`, and on that edge `chg_sel_n` goes low. The block sends `cmd_last`+1 nibbles, nibble k taken from `cmd_words[4k+3:4k]`, starting with k=0. `chg_sel_n` returns high on the edge where the synchronised acknowledge is seen released after the last nibble.
- R3: `chg_data` is set on entry to a nibble and holds for two clock cycles before `chg_req_n` falls. It stays unchanged until the synchronised acknowledge for that nibble is released.
- R4: `chg_req_n` is low only while `chg_sel_n` is low. It rises on the edge where the synchronised `chg_ack_n` is seen low. The next nibble begins only once the synchronised `chg_ack_n` is seen high.
- R5: Every input from the device passes through two flip-flops. A change on `chg_help_n`, `chg_close` or `chg_check` is visible at the flag outputs after the second rising edge, and not after the first.
- R6: In either handshake wait, if the acknowledge condition is still absent on the edge where the wait counter equals `tmo_lim`, the block aborts. `chg_req_n` is then low for exactly `tmo_lim`+1 cycles. On abort, `chg_req_n` and `chg_sel_n` go high and `cmd_err` goes to 1. `cmd_err` stays at 1 until the next accepted start clears it.
- R7: On the edge after a synchronised falling edge of `chg_strb_n` is detected, `stat_nib` takes the synchronised `chg_stat` and `stat_valid` is high for exactly one cycle.
- R8: A `stat_rd` high for a cycle marks the held nibble as read. If a new nibble is captured while the held one is unread and `stat_rd` is low in that cycle, `stat_ovr` goes to 1 and stays at 1 until reset. The new nibble still replaces the old one.
- R9: `dev_fault` is the inverse of the synchronised `chg_help_n`. `dev_closed` follows `chg_close` and `dev_powered` follows `chg_check`.
- R10: `cmd_busy` is high exactly while `chg_sel_n` is low. A `cmd_start` while busy has no effect on the command in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse for a command |
| cmd_last | input | 4 | Index of the last nibble (count minus one) |
| cmd_words | input | 64 | Command nibbles, nibble 0 in bits 3:0 |
| tmo_lim | input | 16 | Handshake wait limit in cycles |
| cmd_busy | output | 1 | Command frame in progress |
| cmd_err | output | 1 | Last command aborted on timeout |
| chg_sel_n | output | 1 | Active-low command frame select |
| chg_data | output | 4 | Command nibble to the device |
| chg_req_n | output | 1 | Active-low nibble request |
| chg_ack_n | input | 1 | Active-low nibble acknowledge |
| chg_strb_n | input | 1 | Active-low status strobe |
| chg_stat | input | 4 | Status nibble from the device |
| chg_help_n | input | 1 | Active-low fault/test mode |
| chg_close | input | 1 | Magazine present and door shut |
| chg_check | input | 1 | Device powered |
| stat_nib | output | 4 | Last captured status nibble |
| stat_valid | output | 1 | One-cycle pulse on capture |
| stat_rd | input | 1 | Marks the held nibble as read |
| stat_ovr | output | 1 | Sticky status overrun |
| dev_fault | output | 1 | Device in fault/test mode |
| dev_closed | output | 1 | Magazine closed |
| dev_powered | output | 1 | Device powered |

## Verification
The bench builds the block with its default parameters: sixteen nibble slots, a 16-bit wait counter and a two-cycle data setup. With these values the full-length command and the single-nibble command are both reachable. Because the wait limit is a port, the bench can drive it with 0, 3, 5 and 100. This covers an immediate abort, a timeout in the release phase, a timeout in the request phase and normal completion, all within a few hundred cycles.

// File: rtl/nhp_pkg.sv
package nhp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_REQ   = 2'd2,
    ST_REL   = 2'd3
  } seq_st_t;
endpackage

// File: rtl/nhp_sync.sv
module nhp_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= RST_VAL[b];
        q[b]      <= RST_VAL[b];
      end else begin
        meta_q[b] <= d[b];
        q[b]      <= meta_q[b];
      end
    end
  end
endmodule

// File: rtl/nhp_stat_cap.sv
module nhp_stat_cap #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_n_s,
  input  logic [NIB_W-1:0] nib_s,
  input  logic             rd,
  output logic [NIB_W-1:0] nib,
  output logic             valid,
  output logic             ovr
);
  logic             prev_q;
  logic             unread_q, unread_d;
  logic             ovr_d;
  logic [NIB_W-1:0] nib_d;
  logic             fall;

  assign fall = prev_q & ~strb_n_s;

  always_comb begin
    nib_d    = nib;
    unread_d = unread_q;
    ovr_d    = ovr;
    if (fall) begin
      nib_d    = nib_s;
      unread_d = 1'b1;
      if (unread_q && !rd) ovr_d = 1'b1;
    end else if (rd) begin
      unread_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      unread_q <= 1'b0;
      ovr      <= 1'b0;
      valid    <= 1'b0;
      nib      <= '0;
    end else begin
      prev_q   <= strb_n_s;
      unread_q <= unread_d;
      ovr      <= ovr_d;
      valid    <= fall;
      if (fall) nib <= nib_d;
    end
  end

  // R7: capture pulse lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R8: overrun is sticky
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
  // R8: overrun only appears together with a capture
  p_ovr_with_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> valid);
endmodule

// File: rtl/nhp_cmd_seq.sv
module nhp_cmd_seq
  import nhp_pkg::*;
#(
  parameter int MAX_NIB   = 16,
  parameter int NIB_W     = 4,
  parameter int TMO_W     = 16,
  parameter int SETUP_CYC = 2,
  localparam int IDX_W    = $clog2(MAX_NIB),
  localparam int WORD_W   = MAX_NIB * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  cmd_last,
  input  logic [WORD_W-1:0] cmd_words,
  input  logic [TMO_W-1:0]  tmo_lim,
  input  logic              ack_n_s,
  output logic              sel_n,
  output logic              req_n,
  output logic [NIB_W-1:0]  data,
  output logic              busy,
  output logic              err
);
  localparam logic [TMO_W-1:0] SETUP_LAST = TMO_W'(SETUP_CYC - 1);

  seq_st_t           st_q, st_d;
  logic [TMO_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic [WORD_W-1:0] words_q, words_d;
  logic              sel_d, req_d, err_d;

  assign data = words_q[idx_q*NIB_W +: NIB_W];
  assign busy = (st_q != ST_IDLE);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    last_d  = last_q;
    words_d = words_q;
    sel_d   = sel_n;
    req_d   = req_n;
    err_d   = err;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          words_d = cmd_words;
          last_d  = cmd_last;
          idx_d   = '0;
          cnt_d   = '0;
          sel_d   = 1'b0;
          err_d   = 1'b0;
          st_d    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cnt_q == SETUP_LAST) begin
          cnt_d = '0;
          req_d = 1'b0;
          st_d  = ST_REQ;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REQ: begin
        if (!ack_n_s) begin
          cnt_d = '0;
          req_d = 1'b1;
          st_d  = ST_REL;
        end else if (cnt_q == tmo_lim) begin
          cnt_d = '0;
          req_d = 1'b1;
          sel_d = 1'b1;
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REL: begin
        if (ack_n_s) begin
          cnt_d = '0;
          if (idx_q == last_q) begin
            sel_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_SETUP;
          end
        end else if (cnt_q == tmo_lim) begin
          cnt_d = '0;
          sel_d = 1'b1;
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      words_q <= '0;
      sel_n   <= 1'b1;
      req_n   <= 1'b1;
      err     <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      words_q <= words_d;
      sel_n   <= sel_d;
      req_n   <= req_d;
      err     <= err_d;
    end
  end

  // R4: request only inside a frame
  p_req_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> !sel_n);
  // R3: data held while requesting and until release is seen
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n || st_q == ST_REL) |-> $stable(data));
  // R6: abort leaves both handshake lines released
  p_abort_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (sel_n && req_n));
  // R10: busy matches the frame
  p_busy_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !sel_n);
  // R10: start during a frame leaves the latched command alone
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(words_q));
endmodule

// File: rtl/nib_cmd_port.sv
module nib_cmd_port #(
  parameter int MAX_NIB   = 16,
  parameter int NIB_W     = 4,
  parameter int TMO_W     = 16,
  parameter int SETUP_CYC = 2,
  localparam int IDX_W    = $clog2(MAX_NIB),
  localparam int WORD_W   = MAX_NIB * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [IDX_W-1:0]  cmd_last,
  input  logic [WORD_W-1:0] cmd_words,
  input  logic [TMO_W-1:0]  tmo_lim,
  output logic              cmd_busy,
  output logic              cmd_err,
  output logic              chg_sel_n,
  output logic [NIB_W-1:0]  chg_data,
  output logic              chg_req_n,
  input  logic              chg_ack_n,
  input  logic              chg_strb_n,
  input  logic [NIB_W-1:0]  chg_stat,
  input  logic              chg_help_n,
  input  logic              chg_close,
  input  logic              chg_check,
  output logic [NIB_W-1:0]  stat_nib,
  output logic              stat_valid,
  input  logic              stat_rd,
  output logic              stat_ovr,
  output logic              dev_fault,
  output logic              dev_closed,
  output logic              dev_powered
);
  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic             ack_n_s, strb_n_s;
  logic [NIB_W-1:0] stat_s;
  logic [2:0]       flag_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  nhp_sync #(.W(1), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_i_n), .d(chg_ack_n), .q(ack_n_s));
  nhp_sync #(.W(1), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_i_n), .d(chg_strb_n), .q(strb_n_s));
  nhp_sync #(.W(NIB_W), .RST_VAL('0)) u_stat_sync (
    .clk(clk), .rst_n(rst_i_n), .d(chg_stat), .q(stat_s));
  nhp_sync #(.W(3), .RST_VAL(3'b100)) u_flag_sync (
    .clk(clk), .rst_n(rst_i_n), .d({chg_help_n, chg_close, chg_check}), .q(flag_s));

  assign dev_fault   = ~flag_s[2];
  assign dev_closed  = flag_s[1];
  assign dev_powered = flag_s[0];

  nhp_cmd_seq #(
    .MAX_NIB(MAX_NIB), .NIB_W(NIB_W), .TMO_W(TMO_W), .SETUP_CYC(SETUP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(cmd_start), .cmd_last(cmd_last),
    .cmd_words(cmd_words), .tmo_lim(tmo_lim), .ack_n_s(ack_n_s),
    .sel_n(chg_sel_n), .req_n(chg_req_n), .data(chg_data),
    .busy(cmd_busy), .err(cmd_err));

  nhp_stat_cap #(.NIB_W(NIB_W)) u_stat (
    .clk(clk), .rst_n(rst_i_n), .strb_n_s(strb_n_s), .nib_s(stat_s),
    .rd(stat_rd), .nib(stat_nib), .valid(stat_valid), .ovr(stat_ovr));
endmodule

// File: tb/test_nib_cmd_port.sv
module test_nib_cmd_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_start, stat_rd;
  logic [3:0]  cmd_last;
  logic [63:0] cmd_words;
  logic [15:0] tmo_lim;
  logic        cmd_busy, cmd_err, chg_sel_n, chg_req_n;
  logic [3:0]  chg_data, chg_stat, stat_nib;
  logic        chg_ack_n = 1'b1;
  logic        chg_strb_n, chg_help_n, chg_close, chg_check;
  logic        stat_valid, stat_ovr, dev_fault, dev_closed, dev_powered;

  always #10 clk = ~clk;

  nib_cmd_port i_nib_cmd_port (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_last(cmd_last),
    .cmd_words(cmd_words), .tmo_lim(tmo_lim), .cmd_busy(cmd_busy), .cmd_err(cmd_err),
    .chg_sel_n(chg_sel_n), .chg_data(chg_data), .chg_req_n(chg_req_n),
    .chg_ack_n(chg_ack_n), .chg_strb_n(chg_strb_n), .chg_stat(chg_stat),
    .chg_help_n(chg_help_n), .chg_close(chg_close), .chg_check(chg_check),
    .stat_nib(stat_nib), .stat_valid(stat_valid), .stat_rd(stat_rd),
    .stat_ovr(stat_ovr), .dev_fault(dev_fault), .dev_closed(dev_closed),
    .dev_powered(dev_powered));

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_rc, m_ph, m_cnt, m_idx, m_last;
  logic [63:0] m_words;
  logic        m_sel, m_req, m_err, m_val, m_unread, m_ovr;
  logic [3:0]  m_stat;
  logic        m_a1, m_a2, m_s1, m_s2, m_s3;
  logic [3:0]  m_d1, m_d2;
  logic [2:0]  m_f1, m_f2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rc <= 0; m_ph <= 0; m_cnt <= 0; m_idx <= 0; m_last <= 0; m_words <= '0;
      m_sel <= 1; m_req <= 1; m_err <= 0; m_val <= 0; m_unread <= 0; m_ovr <= 0;
      m_stat <= '0; m_a1 <= 1; m_a2 <= 1; m_s1 <= 1; m_s2 <= 1; m_s3 <= 1;
      m_d1 <= '0; m_d2 <= '0; m_f1 <= 3'b100; m_f2 <= 3'b100;
    end else if (m_rc < 2) begin
      m_rc <= m_rc + 1;
    end else begin
      m_a1 <= chg_ack_n;  m_a2 <= m_a1;
      m_s1 <= chg_strb_n; m_s2 <= m_s1; m_s3 <= m_s2;
      m_d1 <= chg_stat;   m_d2 <= m_d1;
      m_f1 <= {chg_help_n, chg_close, chg_check}; m_f2 <= m_f1;
      if (m_s3 && !m_s2) begin
        m_stat <= m_d2; m_val <= 1; m_unread <= 1;
        if (m_unread && !stat_rd) m_ovr <= 1;
      end else begin
        m_val <= 0;
        if (stat_rd) m_unread <= 0;
      end
      case (m_ph)
        0: if (cmd_start) begin
             m_words <= cmd_words; m_last <= int'(cmd_last); m_idx <= 0;
             m_cnt <= 0; m_sel <= 0; m_err <= 0; m_ph <= 1;
           end
        1: if (m_cnt == 1) begin m_cnt <= 0; m_req <= 0; m_ph <= 2; end
           else m_cnt <= m_cnt + 1;
        2: if (!m_a2) begin m_cnt <= 0; m_req <= 1; m_ph <= 3; end
           else if (m_cnt == int'(tmo_lim)) begin
             m_cnt <= 0; m_req <= 1; m_sel <= 1; m_err <= 1; m_ph <= 0;
           end else m_cnt <= m_cnt + 1;
        default: if (m_a2) begin
             m_cnt <= 0;
             if (m_idx == m_last) begin m_sel <= 1; m_ph <= 0; end
             else begin m_idx <= m_idx + 1; m_ph <= 1; end
           end else if (m_cnt == int'(tmo_lim)) begin
             m_cnt <= 0; m_sel <= 1; m_err <= 1; m_ph <= 0;
           end else m_cnt <= m_cnt + 1;
      endcase
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2",  "sel_n",   chg_sel_n,  m_sel);
      chk("R4",  "req_n",   chg_req_n,  m_req);
      chk("R3",  "data",    chg_data,   m_words[m_idx*4 +: 4]);
      chk("R10", "busy",    cmd_busy,   m_ph != 0);
      chk("R6",  "err",     cmd_err,    m_err);
      chk("R7",  "valid",   stat_valid, m_val);
      chk("R7",  "nib",     stat_nib,   m_stat);
      chk("R8",  "ovr",     stat_ovr,   m_ovr);
      chk("R9",  "fault",   dev_fault,  !m_f2[2]);
      chk("R9",  "closed",  dev_closed, m_f2[1]);
      chk("R9",  "powered", dev_powered, m_f2[0]);
    end
  end

  // ---------------- device model ----------------
  int ack_dly = 1, rel_dly = 1, dcnt = 0;
  bit dev_mute = 0, dev_stuck = 0;
  logic [3:0] rx_q[$];
  int req_run = 0, last_run = 0, n_val = 0;
  logic [3:0] last_nib = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chg_ack_n = 1'b1; dcnt = 0;
    end else if (!chg_req_n && chg_ack_n && !dev_mute) begin
      if (dcnt >= ack_dly) begin chg_ack_n = 1'b0; rx_q.push_back(chg_data); dcnt = 0; end
      else dcnt++;
    end else if (chg_req_n && !chg_ack_n && !dev_stuck) begin
      if (dcnt >= rel_dly) begin chg_ack_n = 1'b1; dcnt = 0; end
      else dcnt++;
    end else dcnt = 0;
    if (!chg_req_n) req_run++;
    else begin if (req_run > 0) last_run = req_run; req_run = 0; end
    if (stat_valid) begin n_val++; last_nib = stat_nib; end
  end

  // ---------------- stimulus ----------------
  task automatic go(input logic [3:0] last, input logic [63:0] w);
    @(negedge clk);
    cmd_start = 1; cmd_last = last; cmd_words = w;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (!cmd_busy) break;
      @(negedge clk);
    end
  endtask

  task automatic run_cmd(input logic [3:0] last, input logic [63:0] w);
    rx_q.delete();
    go(last, w);
    wait_idle();
    chk("R2", "nibble count", rx_q.size(), int'(last) + 1);
    for (int k = 0; k <= int'(last) && k < rx_q.size(); k++)
      chk("R2", "nibble order", rx_q[k], w[k*4 +: 4]);
    chk("R6", "no error", cmd_err, 0);
  endtask

  task automatic send_stat(input logic [3:0] v);
    chg_stat = v;
    @(negedge clk); chg_strb_n = 0;
    repeat (3) @(negedge clk);
    chg_strb_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    cmd_start = 0; cmd_last = 0; cmd_words = '0; tmo_lim = 16'd100; stat_rd = 0;
    chg_strb_n = 1; chg_stat = 0; chg_help_n = 1; chg_close = 0; chg_check = 0;
    rst_n = 1;
    #3 rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "sel_n in reset", chg_sel_n, 1);
    chk("R1", "req_n in reset", chg_req_n, 1);
    chk("R1", "busy in reset", cmd_busy, 0);
    cmp_en = 1;
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "err after reset", cmd_err, 0);
    chk("R1", "valid after reset", stat_valid, 0);
    chk("R1", "ovr after reset", stat_ovr, 0);

    // R2 R3 R4: three nibbles
    run_cmd(4'd2, 64'h0000_0000_0000_0A5C);
    // R2: full length, fastest device
    ack_dly = 0; rel_dly = 0;
    run_cmd(4'd15, 64'h0123_4567_89AB_CDEF);
    // R2: single nibble, slow device
    ack_dly = 4; rel_dly = 3;
    run_cmd(4'd0, 64'h0000_0000_0000_0007);
    ack_dly = 1; rel_dly = 1;

    // R10: start while busy is ignored
    rx_q.delete();
    go(4'd2, 64'h0000_0000_0000_0321);
    repeat (5) @(negedge clk);
    chk("R10", "busy mid-command", cmd_busy, 1);
    go(4'd5, 64'h0000_0000_00FE_DCBA);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R10", "ignored start count", rx_q.size(), 3);
    chk("R10", "ignored start data", rx_q.size() > 2 ? rx_q[2] : 4'hx, 4'h3);
    chk("R10", "idle after", cmd_busy, 0);

    // R6: timeout while waiting for acknowledge
    dev_mute = 1; tmo_lim = 16'd5;
    go(4'd1, 64'h0000_0000_0000_0099);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R6", "err on request timeout", cmd_err, 1);
    chk("R6", "sel released", chg_sel_n, 1);
    chk("R6", "req low cycles", last_run, 6);
    dev_mute = 0; tmo_lim = 16'd100;
    run_cmd(4'd1, 64'h0000_0000_0000_0042);

    // R6: timeout while waiting for release
    dev_stuck = 1; tmo_lim = 16'd3;
    go(4'd2, 64'h0000_0000_0000_0111);
    wait_idle();
    chk("R6", "err on release timeout", cmd_err, 1);
    chk("R6", "req released", chg_req_n, 1);
    dev_stuck = 0;
    repeat (6) @(negedge clk);
    // R6: limit of zero aborts at once
    tmo_lim = 16'd0;
    go(4'd0, 64'h0000_0000_0000_0005);
    wait_idle();
    chk("R6", "err with zero limit", cmd_err, 1);
    repeat (6) @(negedge clk);
    tmo_lim = 16'd100;

    // R5 R9: flag synchronisation and polarity
    @(negedge clk); chg_close = 1;
    @(negedge clk); chk("R5", "closed after one edge", dev_closed, 0);
    @(negedge clk); chk("R5", "closed after two edges", dev_closed, 1);
    chg_help_n = 0; chg_check = 1;
    repeat (3) @(negedge clk);
    chk("R9", "fault", dev_fault, 1);
    chk("R9", "powered", dev_powered, 1);
    chg_help_n = 1;
    repeat (3) @(negedge clk);
    chk("R9", "fault cleared", dev_fault, 0);

    // R7 R8: status capture
    send_stat(4'h3);
    chk("R7", "valid count", n_val, 1);
    chk("R7", "captured nibble", last_nib, 4'h3);
    pulse_rd();
    send_stat(4'h9);
    pulse_rd();
    chk("R8", "no overrun when read", stat_ovr, 0);
    chk("R7", "second nibble", stat_nib, 4'h9);
    send_stat(4'h5);
    send_stat(4'h6);
    chk("R8", "overrun set", stat_ovr, 1);
    chk("R8", "newest nibble kept", stat_nib, 4'h6);
    pulse_rd();
    send_stat(4'hC);
    chk("R8", "overrun sticky", stat_ovr, 1);
    chk("R7", "valid total", n_val, 5);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule